// File: doc/BRIEF.md
# Interrupt Enable and Mode Control

This block keeps the processor's maskable-interrupt state: a pair of enable flip-flops that always move together, a two-bit interrupt mode, and the halted condition. The instruction decoder sends it one strobe per cycle, for at most one of these instructions: disable interrupts, enable interrupts, halt, or the second byte of the extended set-mode instruction (that byte is presented on `im_byte`). The block answers in the same cycle with the instruction's cycle cost and whether the program counter moves past it.

Halt is modelled by a two-state machine. `ST_RUN` is normal execution. The transition `halt_enter` (halt strobe in `ST_RUN`) leads to `ST_HALTED`. In `ST_HALTED` every cycle is one repeated idle operation costing 4 cycles, with no program-counter advance, and decoder strobes are ignored. The transition `irq_wake` (interrupt request while the first enable flip-flop is set) returns to `ST_RUN`. Reset forces `ST_RUN` from either state.

The set-mode decode accepts eight second-byte values, including undocumented aliases, and folds them onto three modes. Any other byte is not a set-mode instruction for this block.

Top module: `intmode_ctrl`

## Requirements
- R1: A disable strobe in `ST_RUN` clears both enable outputs at the next clock edge, and in that cycle drives `op_cost`=4 and `pc_advance`=1.
- R2: An enable strobe in `ST_RUN` sets both enable outputs at the next clock edge, and in that cycle drives `op_cost`=4 and `pc_advance`=1.
- R3: A set-mode strobe in `ST_RUN` with `im_byte` equal to 0x46, 0x4E, 0x66 or 0x6E selects mode 0. With 0x56 or 0x76 it selects mode 1, and with 0x5E or 0x7E it selects mode 2. The new mode is visible after the next edge, and the cycle drives `op_cost`=8 and `pc_advance`=1.
- R4: `int_mode` encodes mode 0 as 2'b00, mode 1 as 2'b01 and mode 2 as 2'b11. The value 2'b10 never appears.
- R5: A set-mode strobe with any other `im_byte` value (for example 0x47, 0x4C or 0x00) leaves the mode unchanged and drives `op_cost`=0 and `pc_advance`=0.
- R6: A halt strobe in `ST_RUN` drives `op_cost`=4 and `pc_advance`=0, and `halted` is 1 from the next edge. Each cycle in `ST_HALTED` drives `op_cost`=4 and `pc_advance`=0.
- R7: In `ST_HALTED`, `irq` with `ien1`=1 makes `halted` 0 after the next edge. With `ien1`=0, `irq` leaves `halted` at 1.
- R8: Reset clears `ien1`, `ien2`, `int_mode` (to 2'b00) and `halted`, including from `ST_HALTED`.
- R9: In `ST_HALTED`, disable, enable, halt and set-mode strobes change neither the enables nor the mode.
- R10: A cycle in `ST_RUN` with no strobe drives `op_cost`=0 and `pc_advance`=0 and changes no state.
- R11: At most one of the four strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stb_di | input | 1 | Disable-interrupts instruction strobe |
| stb_ei | input | 1 | Enable-interrupts instruction strobe |
| stb_halt | input | 1 | Halt instruction strobe |
| stb_im | input | 1 | Set-mode second-byte strobe |
| im_byte | input | 8 | Second byte of the set-mode instruction |
| irq | input | 1 | Maskable interrupt request |
| ien1 | output | 1 | First enable flip-flop |
| ien2 | output | 1 | Second enable flip-flop |
| int_mode | output | 2 | Interrupt mode, encoded as in R4 |
| halted | output | 1 | 1 while in `ST_HALTED` |
| pc_advance | output | 1 | Program counter moves past this instruction |
| op_cost | output | 4 | Cycle cost of this cycle's operation |

## Verification
The assertions check on every cycle that disable and enable reach both flip-flops, that the mode code never takes the unused value, and that a rejected byte leaves the mode alone. They also check that `ST_HALTED` holds without a qualified interrupt and that nothing moves the enables or the mode while halted. The bench's scenarios are needed to show the full byte-to-mode table including every alias, the exact cost and advance values, the release from halt, and the return from `ST_HALTED` through reset.

// File: rtl/intmode_pkg.sv
package intmode_pkg;
    typedef enum logic [0:0] {ST_RUN, ST_HALTED} run_state_e;

    localparam int COST_W     = 4;
    localparam int COST_SHORT = 4;
    localparam int COST_MODE  = 8;

    localparam logic [1:0] MODE_ZERO = 2'b00;
    localparam logic [1:0] MODE_ONE  = 2'b01;
    localparam logic [1:0] MODE_TWO  = 2'b11;
endpackage

// File: rtl/imode_decode.sv
module imode_decode
    import intmode_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] code,
    output logic              valid,
    output logic [1:0]        mode
);
    // Accepted shape: 01 x yy 110, with bit 5 a don't-care alias bit.
    localparam logic [1:0] HI_TAG = 2'b01;
    localparam logic [2:0] LO_TAG = 3'b110;

    always_comb begin
        valid = (code[7:6] == HI_TAG) && (code[2:0] == LO_TAG);
        unique case (code[4:3])
            2'b10:   mode = MODE_ONE;
            2'b11:   mode = MODE_TWO;
            default: mode = MODE_ZERO;
        endcase
    end
endmodule

// File: rtl/ien_pair.sv
module ien_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set,
    output logic ien1,
    output logic ien2
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien1 <= 1'b0;
            ien2 <= 1'b0;
        end else if (clr) begin
            ien1 <= 1'b0;
            ien2 <= 1'b0;
        end else if (set) begin
            ien1 <= 1'b1;
            ien2 <= 1'b1;
        end
    end

    assert_clr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!ien1 && !ien2));
    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !clr) |=> (ien1 && ien2));
endmodule

// File: rtl/halt_fsm.sv
module halt_fsm
    import intmode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_req,
    input  logic       wake,
    output run_state_e state
);
    run_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:    if (halt_req) nxt = ST_HALTED;   // halt_enter
            ST_HALTED: if (wake)     nxt = ST_RUN;      // irq_wake
            default:   nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    assert_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && halt_req) |=> (state == ST_HALTED));
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALTED && !wake) |=> (state == ST_HALTED));
    assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALTED && wake) |=> (state == ST_RUN));
endmodule

// File: rtl/intmode_ctrl.sv
module intmode_ctrl
    import intmode_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_di,
    input  logic              stb_ei,
    input  logic              stb_halt,
    input  logic              stb_im,
    input  logic [BYTE_W-1:0] im_byte,
    input  logic              irq,
    output logic              ien1,
    output logic              ien2,
    output logic [1:0]        int_mode,
    output logic              halted,
    output logic              pc_advance,
    output logic [COST_W-1:0] op_cost
);
    run_state_e state;
    logic       im_valid;
    logic [1:0] im_sel;
    logic       run;
    logic       acc_di, acc_ei, acc_halt, acc_im;
    logic [1:0] mode_q;

    imode_decode #(.BYTE_W(BYTE_W)) u_dec (
        .code  (im_byte),
        .valid (im_valid),
        .mode  (im_sel)
    );

    assign run      = (state == ST_RUN);
    assign acc_di   = run && stb_di;
    assign acc_ei   = run && stb_ei;
    assign acc_halt = run && stb_halt;
    assign acc_im   = run && stb_im && im_valid;

    ien_pair u_ien (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_di),
        .set   (acc_ei),
        .ien1  (ien1),
        .ien2  (ien2)
    );

    halt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_req (acc_halt),
        .wake     (irq && ien1),
        .state    (state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      mode_q <= MODE_ZERO;
        else if (acc_im) mode_q <= im_sel;
    end

    // Output process: cost and advance per state.
    always_comb begin
        pc_advance = 1'b0;
        op_cost    = '0;
        unique case (state)
            ST_RUN: begin
                pc_advance = acc_di || acc_ei || acc_im;
                if (acc_im)
                    op_cost = COST_W'(COST_MODE);
                else if (acc_di || acc_ei || acc_halt)
                    op_cost = COST_W'(COST_SHORT);
            end
            ST_HALTED: op_cost = COST_W'(COST_SHORT);
            default: ;
        endcase
    end

    assign int_mode = mode_q;
    assign halted   = (state == ST_HALTED);

    assert_mode_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int_mode != 2'b10);
    assert_bad_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_im && !im_valid) |=> $stable(int_mode));
    assert_halt_no_adv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !pc_advance);
    assert_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && irq && !ien1) |=> halted);
    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(int_mode) && $stable(ien1) && $stable(ien2)));
    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stb_di, stb_ei, stb_halt, stb_im}));
endmodule

// File: tb/sim_intmode_ctrl.sv
module sim_intmode_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb_di = 0, stb_ei = 0, stb_halt = 0, stb_im = 0, irq = 0;
    logic [7:0] im_byte = 8'h00;
    logic       ien1, ien2, halted, pc_advance;
    logic [1:0] int_mode;
    logic [3:0] op_cost;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;   // 4 ns period

    intmode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .stb_di(stb_di), .stb_ei(stb_ei),
        .stb_halt(stb_halt), .stb_im(stb_im), .im_byte(im_byte), .irq(irq),
        .ien1(ien1), .ien2(ien2), .int_mode(int_mode), .halted(halted),
        .pc_advance(pc_advance), .op_cost(op_cost)
    );

    typedef struct {
        string      req;
        logic       adv;
        logic [3:0] cost;
        logic       ie;
        logic [1:0] mode;
        logic       hlt;
    } exp_t;

    exp_t sb[$];

    // Reference model state
    logic       m_ie = 0;
    logic [1:0] m_mode = 2'b00;
    logic       m_hlt = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic byte_ok(input logic [7:0] b, output logic [1:0] m);
        case (b)
            8'h46, 8'h4E, 8'h66, 8'h6E: begin m = 2'b00; return 1'b1; end
            8'h56, 8'h76:               begin m = 2'b01; return 1'b1; end
            8'h5E, 8'h7E:               begin m = 2'b11; return 1'b1; end
            default:                    begin m = 2'b00; return 1'b0; end
        endcase
    endfunction

    // Driver: one cycle of stimulus, expectations pushed to the scoreboard.
    task automatic step(input string req, input logic di, input logic ei,
                        input logic ht, input logic im, input logic [7:0] b,
                        input logic rq);
        exp_t e;
        logic [1:0] bm;
        logic ok;
        @(negedge clk);
        stb_di = di; stb_ei = ei; stb_halt = ht; stb_im = im; im_byte = b; irq = rq;
        ok = byte_ok(b, bm);
        e.req = req;
        e.adv = 0; e.cost = 0;
        if (m_hlt) begin
            e.cost = 4;
            if (rq && m_ie) m_hlt = 0;
        end else if (di) begin
            e.adv = 1; e.cost = 4; m_ie = 0;
        end else if (ei) begin
            e.adv = 1; e.cost = 4; m_ie = 1;
        end else if (ht) begin
            e.cost = 4; m_hlt = 1;
        end else if (im && ok) begin
            e.adv = 1; e.cost = 8; m_mode = bm;
        end
        e.ie = m_ie; e.mode = m_mode; e.hlt = m_hlt;
        sb.push_back(e);
    endtask

    // Monitor: compares combinational outputs before the edge, state after it.
    initial begin
        forever begin
            exp_t e;
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                chk(e.req, "pc_advance", pc_advance, e.adv);
                chk(e.req, "op_cost", op_cost, e.cost);
                @(posedge clk);
                #1;
                chk(e.req, "ien1", ien1, e.ie);
                chk(e.req, "ien2", ien2, e.ie);
                chk(e.req, "int_mode", int_mode, e.mode);
                chk(e.req, "halted", halted, e.hlt);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        stb_di = 0; stb_ei = 0; stb_halt = 0; stb_im = 0; irq = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_ie = 0; m_mode = 2'b00; m_hlt = 0;
        #1;
        chk("R8", "reset ien1", ien1, 0);
        chk("R8", "reset ien2", ien2, 0);
        chk("R8", "reset int_mode", int_mode, 0);
        chk("R8", "reset halted", halted, 0);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] good [8] = '{8'h56, 8'h5E, 8'h46, 8'h7E, 8'h4E, 8'h76, 8'h66, 8'h6E};
        do_reset();
        step("R10", 0, 0, 0, 0, 8'h00, 0);
        step("R2", 0, 1, 0, 0, 8'h00, 0);
        step("R1", 1, 0, 0, 0, 8'h00, 0);
        step("R2", 0, 1, 0, 0, 8'h00, 0);
        foreach (good[i]) step("R3_R4", 0, 0, 0, 1, good[i], 0);
        step("R3", 0, 0, 0, 1, 8'h5E, 0);
        step("R5", 0, 0, 0, 1, 8'h47, 0);
        step("R5", 0, 0, 0, 1, 8'h4C, 0);
        step("R5", 0, 0, 0, 1, 8'h00, 0);
        step("R10", 0, 0, 0, 0, 8'h00, 1);
        step("R1", 1, 0, 0, 0, 8'h00, 0);
        step("R6", 0, 0, 1, 0, 8'h00, 0);
        step("R6", 0, 0, 0, 0, 8'h00, 0);
        step("R7", 0, 0, 0, 0, 8'h00, 1);
        step("R9", 0, 1, 0, 0, 8'h00, 0);
        step("R9", 0, 0, 0, 1, 8'h46, 0);
        step("R7", 0, 0, 0, 0, 8'h00, 1);
        repeat (3) @(negedge clk);
        do_reset();
        step("R2", 0, 1, 0, 0, 8'h00, 0);
        step("R3", 0, 0, 0, 1, 8'h56, 0);
        step("R6", 0, 0, 1, 0, 8'h00, 0);
        step("R9", 1, 0, 0, 0, 8'h00, 0);
        step("R9", 0, 0, 0, 1, 8'h7E, 0);
        step("R9", 0, 0, 1, 0, 8'h00, 0);
        step("R7", 0, 0, 0, 0, 8'h00, 1);
        step("R10", 0, 0, 0, 0, 8'h00, 0);
        step("R6", 0, 0, 1, 0, 8'h00, 0);
        repeat (3) @(negedge clk);
        do_reset();
        step("R10", 0, 0, 0, 0, 8'h00, 0);
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule